// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that uses register windows. Software always sees 32 registers. Eight globals are common to every window. The other 24 come from a window selected by a current window pointer. A window has three groups of eight: outs, locals and ins. Neighbouring windows overlap, so the outs of a caller become the ins of its callee once a call has moved the pointer. The number of windows is a parameter. Physical storage is eight globals plus sixteen registers per window. The ins of a window are stored as the outs of the next-higher window, taken modulo the window count.

The block has two combinational read ports and one write port. It also takes a window operation code that moves the window pointer on a call (save), a return (restore), a trap entry or a return from trap. Every move is checked against a window-invalid bitmask. If a save would land on an invalid window, the block raises an overflow request. If a restore or a return from trap would land on an invalid window, it raises an underflow request. The block only raises these requests; it does not spill or fill any window, so that work is left to the trap software. A control write port loads the pointer and the mask directly.

Top module: `win_regfile`

## Requirements
- R1: Register address 0–7 selects a global that is shared by all windows. 8–15 selects the outs and 16–23 the locals of the current window, and these are private to that window. 24–31 selects the ins. A write becomes readable on the read ports in the cycle after its clock edge.
- R2: Register 0 always reads zero on both read ports, and a write to it has no effect.
- R3: The ins of window w are the same storage as the outs of window (w+1) mod NWIN. After a save, a value that the caller wrote to out k reads back as in k of the callee.
- R4: op_i encoding: 0 none, 1 save, 2 restore, 3 trap entry, 4 return from trap, 5–7 none. Save and trap entry decrement the window pointer, and 0 wraps to NWIN−1. Restore and return from trap increment it, and NWIN−1 wraps to 0. The new pointer shows on cwp_o after the clock edge.
- R5: In the same cycle as the operation, ovf_trap_o is high when a save targets a window whose mask bit is set, and unf_trap_o is high when a restore or return from trap does. A trap entry never raises a request.
- R6: While a trap request is high, the window pointer stays unchanged and the destination write is dropped.
- R7: During a save or restore, both read ports use the old window, and the destination write goes to the new window at the same clock edge.
- R8: An all-zero mask raises no trap request for any operation.
- R9: Reset sets the window pointer to NWIN−1 and the mask to 1 (only bit 0 set), and both trap requests are low.
- R10: ctl_we_i loads the mask from wim_wdata_i and the pointer from cwp_wdata_i at the next edge. A pointer value of NWIN or more is ignored, and the pointer keeps its old value. While ctl_we_i is high, op_i is ignored and no trap request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs1_addr_i | input | 5 | Read port 1 register address |
| rs1_data_o | output | XLEN | Read port 1 data, combinational |
| rs2_addr_i | input | 5 | Read port 2 register address |
| rs2_data_o | output | XLEN | Read port 2 data, combinational |
| we_i | input | 1 | Destination write enable |
| rd_addr_i | input | 5 | Destination register address |
| rd_data_i | input | XLEN | Destination write data |
| op_i | input | 3 | Window operation code |
| ctl_we_i | input | 1 | Load pointer and mask |
| cwp_wdata_i | input | 5 | Window pointer load value |
| wim_wdata_i | input | NWIN | Invalid-window mask load value |
| cwp_o | output | 5 | Current window pointer |
| wim_o | output | NWIN | Invalid-window mask |
| ovf_trap_o | output | 1 | Window overflow trap request |
| unf_trap_o | output | 1 | Window underflow trap request |

## Verification
The read data and both trap requests are combinational. They are checked one time unit after the inputs are driven in the low clock phase, before the edge that commits the operation. The window pointer, the mask and written registers change at the next rising edge. The bench samples them in the following low phase, so a value checked there reflects exactly one edge. Write suppression and the old-window/new-window split of save and restore are checked at the read ports after that edge, by reading both the new window's register and the overlapping register of the neighbouring window.

// File: rtl/win_rf_pkg.sv
package win_rf_pkg;
  localparam int unsigned RADDR_W = 5;
  localparam int unsigned PTR_W   = 5;
  localparam int unsigned WSLOTS  = 16;

  typedef enum logic [2:0] {
    WOP_NONE    = 3'd0,
    WOP_SAVE    = 3'd1,
    WOP_RESTORE = 3'd2,
    WOP_TRAP    = 3'd3,
    WOP_RETT    = 3'd4
  } win_op_e;
endpackage

// File: rtl/win_rf_map.sv
module win_rf_map
  import win_rf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = 7
) (
  input  logic [PTR_W-1:0]   cwp_i,
  input  logic [RADDR_W-1:0] addr_i,
  output logic               glob_o,
  output logic [PW-1:0]      idx_o
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NWIN - 1);

  logic [PTR_W-1:0] win;
  logic [3:0]       slot;

  always_comb begin
    glob_o = (addr_i[4:3] == 2'b00);
    // ins live in the next window's outs
    if (addr_i[4:3] == 2'b11) win = (cwp_i == TOP) ? '0 : cwp_i + 1'b1;
    else                      win = cwp_i;
    slot = {addr_i[4:3] == 2'b10, addr_i[2:0]};
    if (glob_o) idx_o = PW'(addr_i[2:0]);
    else        idx_o = PW'(int'(win) * WSLOTS + int'(slot));
  end
endmodule

// File: rtl/win_rf_ctl.sv
module win_rf_ctl
  import win_rf_pkg::*;
#(
  parameter int unsigned NWIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             ctl_we_i,
  input  logic [PTR_W-1:0] cwp_wdata_i,
  input  logic [NWIN-1:0]  wim_wdata_i,
  output logic [PTR_W-1:0] cwp_o,
  output logic [NWIN-1:0]  wim_o,
  output logic [PTR_W-1:0] dst_cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NWIN - 1);
  localparam logic [NWIN-1:0]  ONE = NWIN'(1);

  logic [PTR_W-1:0] cwp_q, cwp_d, cwp_dn, cwp_up;
  logic [NWIN-1:0]  wim_q;
  logic             hit_dn, hit_up;
  win_op_e          op;

  always_comb begin
    op     = win_op_e'(op_i);
    cwp_dn = (cwp_q == '0) ? TOP : cwp_q - 1'b1;
    cwp_up = (cwp_q == TOP) ? '0 : cwp_q + 1'b1;
    hit_dn = |(wim_q & (ONE << cwp_dn));
    hit_up = |(wim_q & (ONE << cwp_up));
    cwp_d  = cwp_q;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    if (!ctl_we_i) begin
      case (op)
        WOP_SAVE:          if (hit_dn) ovf_o = 1'b1; else cwp_d = cwp_dn;
        WOP_TRAP:          cwp_d = cwp_dn;
        WOP_RESTORE,
        WOP_RETT:          if (hit_up) unf_o = 1'b1; else cwp_d = cwp_up;
        default:           cwp_d = cwp_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= TOP;
      wim_q <= ONE;
    end else if (ctl_we_i) begin
      wim_q <= wim_wdata_i;
      if (cwp_wdata_i <= TOP) cwp_q <= cwp_wdata_i;
    end else begin
      cwp_q <= cwp_d;
    end
  end

  assign cwp_o     = cwp_q;
  assign wim_o     = wim_q;
  assign dst_cwp_o = cwp_d;
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import win_rf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [4:0]         rs1_addr_i,
  output logic [XLEN-1:0]    rs1_data_o,
  input  logic [4:0]         rs2_addr_i,
  output logic [XLEN-1:0]    rs2_data_o,
  input  logic               we_i,
  input  logic [4:0]         rd_addr_i,
  input  logic [XLEN-1:0]    rd_data_i,
  input  logic [2:0]         op_i,
  input  logic               ctl_we_i,
  input  logic [4:0]         cwp_wdata_i,
  input  logic [NWIN-1:0]    wim_wdata_i,
  output logic [4:0]         cwp_o,
  output logic [NWIN-1:0]    wim_o,
  output logic               ovf_trap_o,
  output logic               unf_trap_o
);
  localparam int unsigned DEPTH = NWIN * WSLOTS;
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned NRD   = 2;

  logic [XLEN-1:0]    glb_q [8];
  logic [XLEN-1:0]    win_q [DEPTH];
  logic [PTR_W-1:0]   dst_cwp;
  logic               ovf, unf;

  logic [RADDR_W-1:0] r_addr [NRD];
  logic [XLEN-1:0]    r_data [NRD];

  win_rf_ctl #(.NWIN(NWIN)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .ctl_we_i    (ctl_we_i),
    .cwp_wdata_i (cwp_wdata_i),
    .wim_wdata_i (wim_wdata_i),
    .cwp_o       (cwp_o),
    .wim_o       (wim_o),
    .dst_cwp_o   (dst_cwp),
    .ovf_o       (ovf),
    .unf_o       (unf)
  );

  assign r_addr[0]  = rs1_addr_i;
  assign r_addr[1]  = rs2_addr_i;
  assign rs1_data_o = r_data[0];
  assign rs2_data_o = r_data[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          glob;
    logic [PW-1:0] idx;

    win_rf_map #(.NWIN(NWIN), .PW(PW)) u_map (
      .cwp_i  (cwp_o),
      .addr_i (r_addr[p]),
      .glob_o (glob),
      .idx_o  (idx)
    );

    always_comb begin
      if (r_addr[p] == '0) r_data[p] = '0;
      else if (glob)       r_data[p] = glb_q[idx[2:0]];
      else                 r_data[p] = win_q[idx];
    end
  end

  // destination uses the post-operation window
  logic          w_glob, w_en;
  logic [PW-1:0] w_idx;

  win_rf_map #(.NWIN(NWIN), .PW(PW)) u_wmap (
    .cwp_i  (dst_cwp),
    .addr_i (rd_addr_i),
    .glob_o (w_glob),
    .idx_o  (w_idx)
  );

  assign w_en = we_i && (rd_addr_i != '0) && !ovf && !unf;

  always_ff @(posedge clk_i) begin
    if (w_en) begin
      if (w_glob) glb_q[w_idx[2:0]] <= rd_data_i;
      else        win_q[w_idx]      <= rd_data_i;
    end
  end

  assign ovf_trap_o = ovf;
  assign unf_trap_o = unf;
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [4:0]      rs1_addr_i,
  input logic [XLEN-1:0] rs1_data_o,
  input logic [4:0]      rs2_addr_i,
  input logic [XLEN-1:0] rs2_data_o,
  input logic [2:0]      op_i,
  input logic            ctl_we_i,
  input logic [4:0]      cwp_o,
  input logic [NWIN-1:0] wim_o,
  input logic            ovf_trap_o,
  input logic            unf_trap_o
);
  localparam logic [4:0] TOP = 5'(NWIN - 1);

  assert_zero_rs1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs1_addr_i == 5'd0 |-> rs1_data_o == '0);

  assert_zero_rs2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs2_addr_i == 5'd0 |-> rs2_data_o == '0);

  assert_save_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !ctl_we_i && !ovf_trap_o) |=>
      cwp_o == (($past(cwp_o) == 5'd0) ? TOP : $past(cwp_o) - 5'd1));

  assert_restore_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !ctl_we_i && !unf_trap_o) |=>
      cwp_o == (($past(cwp_o) == TOP) ? 5'd0 : $past(cwp_o) + 5'd1));

  assert_ovf_only_save_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap_o |-> (op_i == 3'd1 && !unf_trap_o));

  assert_unf_only_return_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_trap_o |-> (op_i == 3'd2 || op_i == 3'd4));

  assert_trap_holds_cwp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_trap_o || unf_trap_o) |=> $stable(cwp_o));

  assert_zero_mask_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wim_o == '0 |-> !(ovf_trap_o || unf_trap_o));

  assert_ctl_no_trap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |-> !(ovf_trap_o || unf_trap_o));

  assert_cwp_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_o <= TOP);
endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (.*);

// File: tb/win_regfile_test.sv
module win_regfile_test;
  localparam int unsigned NWIN = 8;
  localparam int unsigned XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [4:0]      rs1_addr_i, rs2_addr_i, rd_addr_i, cwp_wdata_i;
  logic [XLEN-1:0] rs1_data_o, rs2_data_o, rd_data_i;
  logic            we_i, ctl_we_i;
  logic [2:0]      op_i;
  logic [NWIN-1:0] wim_wdata_i, wim_o;
  logic [4:0]      cwp_o;
  logic            ovf_trap_o, unf_trap_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  win_regfile #(.NWIN(NWIN), .XLEN(XLEN)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    we_i = 0; rd_addr_i = 0; rd_data_i = 0; op_i = 0;
    ctl_we_i = 0; cwp_wdata_i = 0; wim_wdata_i = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1; rd_addr_i = a; rd_data_i = d;
    @(negedge clk_i);
    idle();
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rs1_addr_i = a;
    #1 d = rs1_data_o;
  endtask

  task automatic ctl(input logic [4:0] c, input logic [NWIN-1:0] m);
    @(negedge clk_i);
    ctl_we_i = 1; cwp_wdata_i = c; wim_wdata_i = m;
    @(negedge clk_i);
    idle();
  endtask

  task automatic op(input logic [2:0] o);
    @(negedge clk_i);
    op_i = o;
    @(negedge clk_i);
    idle();
  endtask

  task automatic t_reset();
    #1;
    chk("R9 cwp", 32'(cwp_o), NWIN - 1);
    chk("R9 wim", 32'(wim_o), 1);
    chk("R9 traps", {30'd0, ovf_trap_o, unf_trap_o}, 0);
  endtask

  task automatic t_globals();
    logic [31:0] d;
    ctl(5'd7, '0);
    wr(5'd3, 32'hA5A5_0003);
    op(3'd1);
    rd(5'd3, d); chk("R1 global shared", d, 32'hA5A5_0003);
    wr(5'd0, 32'hDEAD_BEEF);
    rd(5'd0, d); chk("R2 r0 rs1", d, 0);
    @(negedge clk_i); rs2_addr_i = 0; #1 chk("R2 r0 rs2", rs2_data_o, 0);
  endtask

  task automatic t_overlap();
    logic [31:0] d;
    ctl(5'd6, '0);
    wr(5'd17, 32'h1111_0017);
    wr(5'd10, 32'h2222_000A);
    op(3'd1);
    chk("R4 save dec", 32'(cwp_o), 5);
    rd(5'd26, d); chk("R3 out becomes in", d, 32'h2222_000A);
    wr(5'd17, 32'h3333_0017);
    op(3'd2);
    chk("R4 restore inc", 32'(cwp_o), 6);
    rd(5'd17, d); chk("R1 locals private", d, 32'h1111_0017);
  endtask

  task automatic t_save_rw();
    logic [31:0] d;
    ctl(5'd5, '0);
    wr(5'd11, 32'hE000_000B);
    wr(5'd27, 32'hC000_001B);
    @(negedge clk_i);
    op_i = 3'd1; we_i = 1; rd_addr_i = 5'd11; rd_data_i = 32'hF000_000B;
    rs1_addr_i = 5'd11; rs2_addr_i = 5'd27;
    #1;
    chk("R7 save src1 old", rs1_data_o, 32'hE000_000B);
    chk("R7 save src2 old", rs2_data_o, 32'hC000_001B);
    @(negedge clk_i); idle();
    rd(5'd11, d); chk("R7 save dst new", d, 32'hF000_000B);
    rd(5'd27, d); chk("R7 caller out kept", d, 32'hE000_000B);
    @(negedge clk_i);
    op_i = 3'd2; we_i = 1; rd_addr_i = 5'd9; rd_data_i = 32'h6000_0009;
    rs1_addr_i = 5'd27;
    #1 chk("R7 restore src old", rs1_data_o, 32'hE000_000B);
    @(negedge clk_i); idle();
    chk("R4 restore back", 32'(cwp_o), 5);
    rd(5'd9, d);  chk("R7 restore dst new", d, 32'h6000_0009);
    rd(5'd11, d); chk("R7 restore out intact", d, 32'hE000_000B);
  endtask

  task automatic t_traps();
    logic [31:0] d;
    ctl(5'd1, 8'h01);
    wr(5'd16, 32'h7777_0010);
    @(negedge clk_i);
    op_i = 3'd1; we_i = 1; rd_addr_i = 5'd16; rd_data_i = 32'h8888_0010;
    #1 chk("R5 overflow", {31'd0, ovf_trap_o}, 1);
    chk("R5 no underflow", {31'd0, unf_trap_o}, 0);
    @(negedge clk_i); idle();
    chk("R6 ovf cwp held", 32'(cwp_o), 1);
    rd(5'd16, d); chk("R6 ovf write dropped", d, 32'h7777_0010);
    @(negedge clk_i); op_i = 3'd3;
    #1 chk("R5 trap entry unchecked", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    @(negedge clk_i); idle();
    chk("R4 trap entry dec", 32'(cwp_o), 0);
    op(3'd4);
    chk("R4 rett inc", 32'(cwp_o), 1);
    ctl(5'd7, 8'h01);
    wr(5'd16, 32'h9999_0010);
    @(negedge clk_i);
    op_i = 3'd2; we_i = 1; rd_addr_i = 5'd16; rd_data_i = 32'hBAD0_0010;
    #1 chk("R5 underflow restore", {31'd0, unf_trap_o}, 1);
    @(negedge clk_i); idle();
    chk("R6 unf cwp held", 32'(cwp_o), 7);
    rd(5'd16, d); chk("R6 unf write dropped", d, 32'h9999_0010);
    @(negedge clk_i); op_i = 3'd4;
    #1 chk("R5 underflow rett", {31'd0, unf_trap_o}, 1);
    @(negedge clk_i); idle();
  endtask

  task automatic t_wrap_nomask();
    ctl(5'd7, '0);
    @(negedge clk_i); op_i = 3'd2;
    #1 chk("R8 restore quiet", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    @(negedge clk_i); idle();
    chk("R4 wrap up", 32'(cwp_o), 0);
    @(negedge clk_i); op_i = 3'd1;
    #1 chk("R8 save quiet", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    @(negedge clk_i); idle();
    chk("R4 wrap down", 32'(cwp_o), 7);
    op(3'd6);
    chk("R4 unused code no move", 32'(cwp_o), 7);
  endtask

  task automatic t_ctl();
    ctl(5'd3, 8'h00);
    chk("R10 cwp load", 32'(cwp_o), 3);
    @(negedge clk_i);
    ctl_we_i = 1; cwp_wdata_i = 5'd8; wim_wdata_i = 8'h10; op_i = 3'd1;
    @(negedge clk_i); idle();
    chk("R10 bad cwp ignored", 32'(cwp_o), 3);
    chk("R10 wim load", 32'(wim_o), 32'h10);
    @(negedge clk_i);
    ctl_we_i = 1; cwp_wdata_i = 5'd5; wim_wdata_i = 8'h10; op_i = 3'd1;
    #1 chk("R10 no trap on load", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    @(negedge clk_i); idle();
    chk("R10 op ignored on load", 32'(cwp_o), 5);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; rs1_addr_i = 0; rs2_addr_i = 0;
    idle();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_globals();
    t_overlap();
    t_save_rw();
    t_traps();
    t_wrap_nomask();
    t_ctl();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule